// File: doc/BRIEF.md
# PCI Function Base Address Decoder

This block keeps the address windows of a single type-0 PCI function: six ordinary base registers and one expansion-ROM base register. Software programs them with configuration writes through a register port that carries a dword offset, four byte enables, write data and a write strobe. The block returns the stored value of the addressed register on a read port. Each region's size and address space (I/O or memory) are fixed by parameters. A size of zero means the region is absent.

From the stored bases and the I/O and memory enable bits of the function's command register, the block builds a registered window for every region: an aligned base, an inclusive limit and a valid flag. It also checks each incoming access address against these windows and raises a one-hot hit for the region that claims it. Windows that cannot be mapped are rejected: an I/O window that reaches past 64K, a memory window that would run past the top of the 32-bit space, and any window whose base is zero.

Top module: `pci_bar_decode`

## Requirements
- R1: Ordinary register i (0..5) sits at byte offset 0x10+4*i and the ROM register sits at byte offset 0x30. The port carries offset bits [7:2]. A read at one of these offsets returns the stored value. Every other offset reads as zero, and a write to it changes no stored register.
- R2: A write with all four byte enables set to an ordinary register of nonzero size S stores (data AND NOT(S-1)) OR T, where T is 1 for an I/O region and 0 for a memory region.
- R3: A write with all four byte enables set to the ROM register of nonzero size S stores data AND (NOT(S-1) OR 1). Bit 0 is kept as the ROM enable.
- R4: A write to a region of size zero, or a write with any byte enable clear, stores the enabled bytes unchanged with no masking.
- R5: After reset every register reads zero, every window is invalid with base and limit all ones, and no hit is raised.
- R6: An I/O window is valid only when the I/O enable is set, the size is nonzero, the base (stored value AND NOT(S-1)) is nonzero and the limit base+S-1 is at most 0xFFFF.
- R7: A memory window is valid only when the memory enable is set, the size is nonzero, the base is nonzero and base+S-1 does not pass 0xFFFFFFFF. The topmost aligned window, ending at 0xFFFFFFFF, is accepted.
- R8: The ROM window is additionally valid only while bit 0 of its stored value is set.
- R9: Window outputs reflect a register write or a change of the command enables after the next rising clock edge, and not before it.
- R10: A hit bit is set for region i when the access is valid, its space matches the region's space, the window is valid and base <= address <= limit. At most one bit is set; among overlapping regions the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration offset bits [7:2] |
| cfg_byte_en | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Stored value at the addressed offset |
| cmd_io_en | input | 1 | I/O space enable from the command register |
| cmd_mem_en | input | 1 | Memory space enable from the command register |
| acc_valid | input | 1 | An access address is present |
| acc_is_io | input | 1 | The access is in I/O space (else memory) |
| acc_addr | input | 32 | Access address |
| win_valid | output | 7 | Per-region window valid |
| win_base | output | 7x32 | Per-region window base, all ones when invalid |
| win_limit | output | 7x32 | Per-region window limit, all ones when invalid |
| hit | output | 7 | One-hot region hit |

## Verification
Every offset of the configuration space is read after reset, and each register is written with all-ones, all-zeros and two mixed patterns, so the masking of I/O, memory, ROM and absent regions is told apart bit by bit; partial writes and writes to unused offsets separate the raw path from the masked one. The windows are compared under all four enable combinations with the ROM enable both set and clear, and at the I/O 64K edge, a zero base and the topmost memory window. Hits are probed one below, at, and one above each edge of every valid window in both spaces, plus a deliberate overlap that shows the lower index winning.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;

    typedef struct packed {
        logic        valid;
        logic [31:0] base;
        logic [31:0] limit;
    } bar_win_t;

    localparam bar_win_t WIN_NONE = '{valid: 1'b0, base: '1, limit: '1};

endpackage

// File: rtl/pci_bar_store.sv
module pci_bar_store #(
    parameter int                     N_REG   = 6,
    parameter logic [N_REG:0][31:0]   SIZES   = '0,
    parameter logic [N_REG:0]         IS_IO   = '0,
    parameter logic [7:0]             BAR_OFS = 8'h10,
    parameter logic [7:0]             ROM_OFS = 8'h30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [7:2]             addr,
    input  logic [3:0]             be,
    input  logic [31:0]            wdata,
    output logic [N_REG:0][31:0]   bar_d,
    output logic [N_REG:0][31:0]   bar_q,
    output logic [31:0]            rdata
);
    localparam int N_ALL = N_REG + 1;

    logic [N_REG:0] sel;

    always_comb begin
        for (int i = 0; i < N_ALL; i++) begin
            if (i == N_REG) sel[i] = (addr == ROM_OFS[7:2]);
            else            sel[i] = (addr == BAR_OFS[7:2] + 6'(i));
        end
    end

    always_comb begin
        bar_d = bar_q;
        rdata = '0;
        for (int i = 0; i < N_ALL; i++) begin
            if (sel[i]) rdata = bar_q[i];
            if (wr_en && sel[i]) begin
                if (be == 4'hF && SIZES[i] != 32'd0) begin
                    if (i == N_REG)
                        bar_d[i] = wdata & (~(SIZES[i] - 32'd1) | 32'd1);
                    else
                        bar_d[i] = (wdata & ~(SIZES[i] - 32'd1)) | {31'd0, IS_IO[i]};
                end else begin
                    for (int b = 0; b < 4; b++)
                        if (be[b]) bar_d[i][8*b +: 8] = wdata[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bar_q <= '0;
        else        bar_q <= bar_d;
    end

    for (genvar gi = 0; gi < N_REG; gi++) begin : g_reg_chk
        if (SIZES[gi] != 32'd0) begin : g_sized
            p_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && sel[gi] && be == 4'hF) |=>
                ((bar_q[gi] & (SIZES[gi] - 32'd1)) == {31'd0, IS_IO[gi]}));
        end
    end

    if (SIZES[N_REG] != 32'd0) begin : g_rom_chk
        p_rom_enable_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && sel[N_REG] && be == 4'hF) |=>
            (bar_q[N_REG][0] == $past(wdata[0])) &&
            ((bar_q[N_REG] & (SIZES[N_REG] - 32'd1) & ~32'd1) == 32'd0));
    end

endmodule

// File: rtl/pci_bar_window.sv
module pci_bar_window
    import pci_bar_pkg::*;
#(
    parameter logic [31:0] SIZE   = 32'h10,
    parameter bit          IS_IO  = 1'b0,
    parameter bit          IS_ROM = 1'b0
) (
    input  logic [31:0] bar,
    input  logic        io_en,
    input  logic        mem_en,
    output bar_win_t    win
);
    localparam logic [31:0] SPAN = SIZE - 32'd1;

    logic [31:0] base;
    logic [32:0] last;
    logic        ok;

    always_comb begin
        base = bar & ~SPAN;
        last = {1'b0, base} + {1'b0, SPAN};
        ok   = (SIZE != 32'd0) && (base != 32'd0);
        if (IS_IO) ok = ok && io_en && (last <= 33'h0_0000_FFFF);
        else       ok = ok && mem_en && !last[32];
        if (IS_ROM) ok = ok && bar[0];
        if (ok) win = '{valid: 1'b1, base: base, limit: last[31:0]};
        else    win = WIN_NONE;
    end

endmodule

// File: rtl/pci_bar_hit.sv
module pci_bar_hit
    import pci_bar_pkg::*;
#(
    parameter int             N_REG = 6,
    parameter logic [N_REG:0] IS_IO = '0
) (
    input  bar_win_t [N_REG:0] win,
    input  logic               acc_valid,
    input  logic               acc_is_io,
    input  logic [31:0]        acc_addr,
    output logic [N_REG:0]     hit
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        hit   = '0;
        for (int i = 0; i <= N_REG; i++) begin
            if (!taken && acc_valid && win[i].valid && (IS_IO[i] == acc_is_io) &&
                acc_addr >= win[i].base && acc_addr <= win[i].limit) begin
                hit[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pci_bar_decode.sv
module pci_bar_decode
    import pci_bar_pkg::*;
#(
    parameter int                   N_REG   = 6,
    parameter logic [N_REG:0][31:0] SIZES   = {32'h0001_0000, 32'h0000_0010, 32'h0000_0100,
                                               32'h0000_0000, 32'h1000_0000, 32'h0000_1000,
                                               32'h0000_0010},
    parameter logic [N_REG:0]       IS_IO   = 7'b001_0001,
    parameter logic [7:0]           BAR_OFS = 8'h10,
    parameter logic [7:0]           ROM_OFS = 8'h30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr_en,
    input  logic [7:2]             cfg_addr,
    input  logic [3:0]             cfg_byte_en,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    input  logic                   cmd_io_en,
    input  logic                   cmd_mem_en,
    input  logic                   acc_valid,
    input  logic                   acc_is_io,
    input  logic [31:0]            acc_addr,
    output logic [N_REG:0]         win_valid,
    output logic [N_REG:0][31:0]   win_base,
    output logic [N_REG:0][31:0]   win_limit,
    output logic [N_REG:0]         hit
);
    localparam int N_ALL = N_REG + 1;

    logic [N_REG:0][31:0] bar_d, bar_q;
    bar_win_t [N_REG:0]   win_d, win_q;

    pci_bar_store #(
        .N_REG(N_REG), .SIZES(SIZES), .IS_IO(IS_IO),
        .BAR_OFS(BAR_OFS), .ROM_OFS(ROM_OFS)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .be(cfg_byte_en), .wdata(cfg_wdata),
        .bar_d(bar_d), .bar_q(bar_q), .rdata(cfg_rdata)
    );

    for (genvar gi = 0; gi < N_ALL; gi++) begin : g_win
        pci_bar_window #(
            .SIZE(SIZES[gi]), .IS_IO(IS_IO[gi]), .IS_ROM(gi == N_REG)
        ) u_win (
            .bar(bar_d[gi]), .io_en(cmd_io_en), .mem_en(cmd_mem_en), .win(win_d[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= {N_ALL{WIN_NONE}};
        else        win_q <= win_d;
    end

    always_comb begin
        for (int i = 0; i < N_ALL; i++) begin
            win_valid[i] = win_q[i].valid;
            win_base[i]  = win_q[i].base;
            win_limit[i] = win_q[i].limit;
        end
    end

    pci_bar_hit #(.N_REG(N_REG), .IS_IO(IS_IO)) u_hit (
        .win(win_q), .acc_valid(acc_valid), .acc_is_io(acc_is_io),
        .acc_addr(acc_addr), .hit(hit)
    );

    p_hit_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    for (genvar gi = 0; gi < N_ALL; gi++) begin : g_chk
        p_invalid_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !win_q[gi].valid |-> (win_q[gi].base == '1 && win_q[gi].limit == '1));
        p_hit_inside_r10: assert property (@(posedge clk) disable iff (!rst_n)
            hit[gi] |-> (acc_valid && win_q[gi].valid &&
                         acc_addr >= win_q[gi].base && acc_addr <= win_q[gi].limit));
        if (IS_IO[gi]) begin : g_io
            p_io_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
                win_q[gi].valid |-> ($past(cmd_io_en) && win_q[gi].limit <= 32'h0000_FFFF &&
                                     win_q[gi].base != 32'd0));
        end else begin : g_mem
            p_mem_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
                win_q[gi].valid |-> ($past(cmd_mem_en) && win_q[gi].limit >= win_q[gi].base));
        end
    end

    p_rom_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_q[N_REG].valid |-> bar_q[N_REG][0]);

endmodule

// File: tb/sim_pci_bar_decode.sv
module sim_pci_bar_decode;

    localparam logic [31:0] SZ [7] = '{32'h10, 32'h1000, 32'h1000_0000, 32'h0,
                                       32'h100, 32'h10, 32'h1_0000};
    localparam logic [6:0]  IOM    = 7'b001_0001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [7:2]        cfg_addr = '0;
    logic [3:0]        cfg_byte_en = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              cmd_io_en = 1'b0;
    logic              cmd_mem_en = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_is_io = 1'b0;
    logic [31:0]       acc_addr = '0;
    logic [6:0]        win_valid;
    logic [6:0][31:0]  win_base;
    logic [6:0][31:0]  win_limit;
    logic [6:0]        hit;

    int checks = 0;
    int fails  = 0;
    logic [31:0] shadow [7];

    always #10 clk = ~clk;

    pci_bar_decode u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_byte_en(cfg_byte_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .acc_valid(acc_valid),
        .acc_is_io(acc_is_io), .acc_addr(acc_addr), .win_valid(win_valid),
        .win_base(win_base), .win_limit(win_limit), .hit(hit)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int slot_of(input logic [7:2] a);
        if (a >= 6'd4 && a <= 6'd9) return int'(a) - 4;
        if (a == 6'd12) return 6;
        return -1;
    endfunction

    function automatic logic [31:0] m_store(input int i, input logic [31:0] old,
                                             input logic [31:0] w, input logic [3:0] be);
        logic [31:0] r;
        if (be == 4'hF && SZ[i] != 0) begin
            if (i == 6) r = w & (~(SZ[i] - 1) | 32'd1);
            else        r = (w & ~(SZ[i] - 1)) | {31'd0, IOM[i]};
        end else begin
            r = old;
            for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = w[8*b +: 8];
        end
        return r;
    endfunction

    function automatic void m_win(input int i, output logic v,
                                  output logic [31:0] b, output logic [31:0] l);
        logic [31:0] base;
        logic [32:0] last;
        logic ok;
        base = shadow[i] & ~(SZ[i] - 1);
        last = {1'b0, base} + {1'b0, SZ[i]} - 33'd1;
        ok = (SZ[i] != 0) && (base != 0);
        if (IOM[i]) ok = ok && cmd_io_en && (last <= 33'h0FFFF);
        else        ok = ok && cmd_mem_en && !last[32];
        if (i == 6) ok = ok && shadow[6][0];
        v = ok;
        b = ok ? base : 32'hFFFF_FFFF;
        l = ok ? last[31:0] : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [6:0] m_hit(input logic v, input logic io, input logic [31:0] a);
        logic wv;
        logic [31:0] wb, wl;
        for (int i = 0; i < 7; i++) begin
            m_win(i, wv, wb, wl);
            if (v && wv && IOM[i] == io && a >= wb && a <= wl) return 7'(1 << i);
        end
        return 7'd0;
    endfunction

    task automatic cfg_wr(input logic [7:2] a, input logic [3:0] be, input logic [31:0] d);
        int s;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_byte_en = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        s = slot_of(a);
        if (s >= 0) shadow[s] = m_store(s, shadow[s], d, be);
    endtask

    task automatic rd_chk(input string req, input logic [7:2] a);
        int s;
        cfg_addr = a;
        #1;
        s = slot_of(a);
        chk(req, $sformatf("read offset %h", {a, 2'b00}), cfg_rdata,
            (s >= 0) ? shadow[s] : 32'd0);
    endtask

    task automatic win_chk(input string req);
        logic v;
        logic [31:0] b, l;
        #1;
        for (int i = 0; i < 7; i++) begin
            m_win(i, v, b, l);
            chk(req, $sformatf("valid[%0d]", i), {31'd0, win_valid[i]}, {31'd0, v});
            chk(req, $sformatf("base[%0d]", i), win_base[i], b);
            chk(req, $sformatf("limit[%0d]", i), win_limit[i], l);
        end
    endtask

    task automatic hit_chk(input string req, input logic v, input logic io, input logic [31:0] a);
        acc_valid = v; acc_is_io = io; acc_addr = a;
        #1;
        chk(req, $sformatf("hit io=%0d addr %h", io, a), {25'd0, hit}, {25'd0, m_hit(v, io, a)});
    endtask

    task automatic cmd_set(input logic io, input logic mem);
        @(negedge clk);
        cmd_io_en = io; cmd_mem_en = mem;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        logic [7:2]  junk [6];
        pats = '{32'hFFFF_FFFF, 32'h1234_5679, 32'hA5A5_A5A4, 32'h0};
        junk = '{6'd0, 6'd1, 6'd10, 6'd11, 6'd13, 6'd63};
        for (int i = 0; i < 7; i++) shadow[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: reset state, all offsets read zero, windows invalid, no hit
        win_chk("R5");
        for (int a = 0; a < 64; a++) rd_chk("R5", 6'(a));
        hit_chk("R5", 1'b1, 1'b0, 32'h0);

        // R1 R2 R3 R4: masking of each register under several patterns
        for (int i = 0; i < 7; i++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:2] a;
                a = (i == 6) ? 6'd12 : 6'(4 + i);
                cfg_wr(a, 4'hF, pats[p]);
                rd_chk((i == 6) ? "R3" : ((SZ[i] == 0) ? "R4" : "R2"), a);
            end
        end

        // R1: writes to unused offsets leave every register alone
        cfg_wr(6'd5, 4'hF, 32'h8000_0000);
        for (int j = 0; j < 6; j++) begin
            cfg_wr(junk[j], 4'hF, 32'hFFFF_FFFF);
            rd_chk("R1", junk[j]);
        end
        for (int a = 0; a < 64; a++) rd_chk("R1", 6'(a));

        // R4: partial writes and the absent region store raw bytes
        cfg_wr(6'd5, 4'b0011, 32'h0000_FFFF);
        rd_chk("R4", 6'd5);
        cfg_wr(6'd4, 4'b1000, 32'hDE00_0000);
        rd_chk("R4", 6'd4);
        cfg_wr(6'd7, 4'hF, 32'hDEAD_BEEF);
        rd_chk("R4", 6'd7);

        // Program a working layout
        cfg_wr(6'd4,  4'hF, 32'h0000_C000);
        cfg_wr(6'd5,  4'hF, 32'h8000_0000);
        cfg_wr(6'd6,  4'hF, 32'hF000_0000);
        cfg_wr(6'd8,  4'hF, 32'h0000_FF00);
        cfg_wr(6'd9,  4'hF, 32'h8000_1000);
        cfg_wr(6'd12, 4'hF, 32'h00C0_0001);

        // R6 R7 R8: every enable combination, ROM enable set then clear
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 4; c++) begin
                cmd_set(c[0], c[1]);
                win_chk(r == 0 ? "R7" : "R8");
            end
            cfg_wr(6'd12, 4'hF, 32'h00C0_0000);
        end
        win_chk("R8");

        // R9: an enable change is not seen before the edge, then is seen after it
        cmd_set(1'b0, 1'b0);
        @(negedge clk);
        cmd_io_en = 1'b1;
        #1;
        chk("R9", "valid[0] before edge", {31'd0, win_valid[0]}, 32'd0);
        @(negedge clk);
        #1;
        chk("R9", "valid[0] after edge", {31'd0, win_valid[0]}, 32'd1);
        cmd_mem_en = 1'b1;
        cfg_wr(6'd12, 4'hF, 32'h00C0_0001);
        win_chk("R9");

        // R6: 64K edge of I/O space and zero base
        cfg_wr(6'd4, 4'hF, 32'h0001_0000);
        win_chk("R6");
        cfg_wr(6'd4, 4'hF, 32'h0000_FFF0);
        win_chk("R6");
        cfg_wr(6'd4, 4'hF, 32'h0000_0000);
        win_chk("R6");
        cfg_wr(6'd4, 4'hF, 32'h0000_C000);
        // R7: zero memory base
        cfg_wr(6'd9, 4'hF, 32'h0000_0000);
        win_chk("R7");
        cfg_wr(6'd9, 4'hF, 32'h8000_1000);
        win_chk("R7");

        // R10: probe each window edge in both spaces
        for (int i = 0; i < 7; i++) begin
            if (win_valid[i]) begin
                logic [31:0] b, l;
                b = win_base[i]; l = win_limit[i];
                for (int s = 0; s < 2; s++) begin
                    hit_chk("R10", 1'b1, s[0], b - 32'd1);
                    hit_chk("R10", 1'b1, s[0], b);
                    hit_chk("R10", 1'b1, s[0], l);
                    hit_chk("R10", 1'b1, s[0], l + 32'd1);
                end
            end
        end
        hit_chk("R10", 1'b0, 1'b0, 32'h8000_0010);
        hit_chk("R10", 1'b0, 1'b1, 32'h0000_C004);

        // R10: overlap, lower index wins
        cfg_wr(6'd9, 4'hF, 32'h8000_0800);
        hit_chk("R10", 1'b1, 1'b0, 32'h8000_0804);
        chk("R10", "overlap winner", {25'd0, hit}, 32'h2);
        hit_chk("R10", 1'b1, 1'b0, 32'h8000_0FFF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule